// File: doc/BRIEF.md
# Event-Counting Interval Timer

This block is a 16-bit down counter that a host loads through two byte-wide write slots. A write to the low slot fills a holding byte only. A write to the high slot loads the counter from the written byte and the holding byte, clears the interrupt flag and arms the timer for exactly one interrupt. A mode input sets what makes the counter step down. In timed mode it steps on a periodic enable strobe. In pulse mode it steps on falling edges of an asynchronous pin, which passes through a synchroniser first.

When the counter steps down from zero it wraps to all ones and keeps counting. The first wrap after a load raises the flag. Later wraps leave the flag alone until the next load re-arms it. The host reads either counter byte combinationally. Reading the low byte clears the flag and reading the high byte does not. This makes the block suitable for a single delay measurement or for counting a set number of external events.

Top module: `tmr_event_timer`

## Requirements
- R1: After reset the flag is 0, the counter reads 0xFFFF, the holding byte is 0xFF and no interrupt is armed.
- R2: A write with `hi_sel_i`=0 stores `wdata_i` in the holding byte and leaves the counter unchanged.
- R3: A write with `hi_sel_i`=1 sets the counter to {`wdata_i`, holding byte} at the next edge, clears the flag and arms one interrupt.
- R4: With `pulse_mode_i`=0 the counter decrements by one at each edge where `tick_i` is 1. The pin has no effect in this mode.
- R5: With `pulse_mode_i`=1 the counter decrements once per high-to-low transition of `pulse_pin_i`, at the third rising edge after the pin falls. Rising transitions and `tick_i` have no effect in this mode.
- R6: A decrement from 0 yields 0xFFFF. If an interrupt is armed, the flag is set at that edge, so a loaded value N raises the flag after N+1 counting events.
- R7: A wrap disarms the timer. Any further wrap before the next high write leaves the flag at 0.
- R8: A read with `hi_sel_i`=0 clears the flag at the next edge. A read with `hi_sel_i`=1 leaves the flag as it was.
- R9: Setting the flag wins over a read clear in the same cycle. A high write wins over a counting event in the same cycle.
- R10: `rdata_o` shows the counter's high byte when `hi_sel_i`=1 and its low byte when it is 0, in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Periodic count enable for timed mode |
| pulse_mode_i | input | 1 | 0 = timed mode, 1 = count pin falling edges |
| pulse_pin_i | input | 1 | Asynchronous event pin |
| wr_i | input | 1 | Host write strobe |
| rd_i | input | 1 | Host read strobe |
| hi_sel_i | input | 1 | Byte slot select: 0 low, 1 high |
| wdata_i | input | 8 | Host write data |
| rdata_o | output | 8 | Selected counter byte |
| flag_o | output | 1 | Interrupt flag |

## Verification
Writes, the read clear, tick-driven decrements and the flag change all take effect at the first rising edge after the cycle that caused them. `rdata_o` follows `hi_sel_i` in the same cycle. A falling edge on the pin moves the counter only at the third rising edge after the fall. The bench drives every input at the falling clock edge and samples 1 ns after the rising edge. A per-cycle model of the requirements keeps its own three-entry pin history, so every compare lands in the cycle where the result is due. Directed checks assert that the counter is still unchanged after the first and second edges of a pin fall and has moved after the third.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int TMR_BYTE_W   = 8;
    localparam int TMR_SYNC_LEN = 2;

    typedef struct packed {
        logic flag;
        logic armed;
    } flag_state_t;
endpackage

// File: rtl/tmr_pulse_sync.sv
module tmr_pulse_sync #(
    parameter int STAGES = tmr_pkg::TMR_SYNC_LEN
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic pin_i,
    output logic fall_o
);
    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0] chain_d, chain_q;
    logic              last_d, last_q;

    assign chain_d[0] = pin_i;
    for (genvar g = 1; g < STAGES; g++) begin : g_chain
        assign chain_d[g] = chain_q[g-1];
    end
    assign last_d = chain_q[LAST];

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            chain_q <= '0;
            last_q  <= 1'b0;
        end else begin
            chain_q <= chain_d;
            last_q  <= last_d;
        end
    end

    assign fall_o = last_q & ~chain_q[LAST];

    AST_FALL_ISOLATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fall_o |=> !fall_o); // R5
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
    parameter int BYTE_W = tmr_pkg::TMR_BYTE_W
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic                  ev_i,
    input  logic                  wr_lo_i,
    input  logic                  load_i,
    input  logic [BYTE_W-1:0]     wdata_i,
    output logic [2*BYTE_W-1:0]   cnt_o,
    output logic                  uf_o
);
    localparam int CNT_W = 2 * BYTE_W;

    typedef struct packed {
        logic [BYTE_W-1:0] latch;
        logic [CNT_W-1:0]  cnt;
    } cnt_state_t;

    cnt_state_t st_d, st_q;
    logic       uf_d;

    always_comb begin
        st_d = st_q;
        uf_d = ev_i & ~load_i & (st_q.cnt == '0);
        if (wr_lo_i) begin
            st_d.latch = wdata_i;
        end
        if (load_i) begin
            st_d.cnt = {wdata_i, st_q.latch};
        end else if (ev_i) begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q.latch <= '1;
            st_q.cnt   <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_o = st_q.cnt;
    assign uf_o  = uf_d;

    AST_LOAD_VALUE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        load_i |=> st_q.cnt == $past({wdata_i, st_q.latch})); // R3
    AST_LATCH_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_lo_i && !ev_i && !load_i |=> $stable(st_q.cnt)); // R2
    AST_WRAP_ONES: assert property (@(posedge clk_i) disable iff (!rst_ni)
        uf_o |=> st_q.cnt == {CNT_W{1'b1}}); // R6
endmodule

// File: rtl/tmr_flag.sv
module tmr_flag (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic uf_i,
    input  logic load_i,
    input  logic rd_lo_i,
    output logic flag_o
);
    import tmr_pkg::*;

    flag_state_t fs_d, fs_q;

    always_comb begin
        fs_d = fs_q;
        if (load_i) begin
            fs_d.armed = 1'b1;
        end else if (uf_i) begin
            fs_d.armed = 1'b0;
        end
        if (uf_i && fs_q.armed) begin
            fs_d.flag = 1'b1;
        end else if (load_i || rd_lo_i) begin
            fs_d.flag = 1'b0;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            fs_q.flag  <= 1'b0;
            fs_q.armed <= 1'b0;
        end else begin
            fs_q <= fs_d;
        end
    end

    assign flag_o = fs_q.flag;

    AST_FLAG_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        uf_i && fs_q.armed |=> flag_o); // R6
    AST_DISARM: assert property (@(posedge clk_i) disable iff (!rst_ni)
        uf_i && !load_i |=> !fs_q.armed); // R7
    AST_NO_REFLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !fs_q.armed && !flag_o && !load_i |=> !flag_o); // R7
    AST_RD_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rd_lo_i && !uf_i |=> !flag_o); // R8
    AST_FLAG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        flag_o && !rd_lo_i && !load_i |=> flag_o); // R8
endmodule

// File: rtl/tmr_event_timer.sv
module tmr_event_timer #(
    parameter int BYTE_W   = tmr_pkg::TMR_BYTE_W,
    parameter int SYNC_LEN = tmr_pkg::TMR_SYNC_LEN
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              tick_i,
    input  logic              pulse_mode_i,
    input  logic              pulse_pin_i,
    input  logic              wr_i,
    input  logic              rd_i,
    input  logic              hi_sel_i,
    input  logic [BYTE_W-1:0] wdata_i,
    output logic [BYTE_W-1:0] rdata_o,
    output logic              flag_o
);
    localparam int CNT_W = 2 * BYTE_W;

    logic             fall;
    logic             ev;
    logic             load;
    logic             wr_lo;
    logic             rd_lo;
    logic             uf;
    logic [CNT_W-1:0] cnt;

    assign load  = wr_i & hi_sel_i;
    assign wr_lo = wr_i & ~hi_sel_i;
    assign rd_lo = rd_i & ~hi_sel_i;
    assign ev    = pulse_mode_i ? fall : tick_i;

    tmr_pulse_sync #(.STAGES(SYNC_LEN)) u_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .pin_i  (pulse_pin_i),
        .fall_o (fall)
    );

    tmr_counter #(.BYTE_W(BYTE_W)) u_cnt (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .ev_i    (ev),
        .wr_lo_i (wr_lo),
        .load_i  (load),
        .wdata_i (wdata_i),
        .cnt_o   (cnt),
        .uf_o    (uf)
    );

    tmr_flag u_flag (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .uf_i    (uf),
        .load_i  (load),
        .rd_lo_i (rd_lo),
        .flag_o  (flag_o)
    );

    assign rdata_o = hi_sel_i ? cnt[CNT_W-1:BYTE_W] : cnt[BYTE_W-1:0];

    AST_TIMED_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !pulse_mode_i && !tick_i && !load |=> $stable(cnt)); // R4
    AST_PULSE_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pulse_mode_i && !fall && !load |=> $stable(cnt)); // R5
    AST_STEP_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ev && !load && cnt != '0 |=> cnt == $past(cnt) - 1'b1); // R4
endmodule

// File: tb/tb_tmr_event_timer.sv
`timescale 1ns/1ps
module tb_tmr_event_timer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0, mode = 1'b0, pin = 1'b0;
    logic       wr = 1'b0, rd = 1'b0, sel = 1'b0;
    logic [7:0] wd = 8'h00;
    logic [7:0] rdata;
    logic       flag;

    int total = 0;
    int fails = 0;

    logic [15:0] m_cnt = 16'hFFFF;
    logic [7:0]  m_latch = 8'hFF;
    logic        m_flag = 1'b0, m_arm = 1'b0;
    logic        h1 = 1'b0, h2 = 1'b0, h3 = 1'b0;

    always #2.5 clk = ~clk;

    tmr_event_timer dut (
        .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .pulse_mode_i(mode),
        .pulse_pin_i(pin), .wr_i(wr), .rd_i(rd), .hi_sel_i(sel),
        .wdata_i(wd), .rdata_o(rdata), .flag_o(flag)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_rd(input logic s, input logic [15:0] c);
        return s ? c[15:8] : c[7:0];
    endfunction

    task automatic step(input logic t, input logic m, input logic p, input logic w,
                        input logic r, input logic s, input logic [7:0] d, input string tag);
        logic ev, ld, uf;
        @(negedge clk);
        tick = t; mode = m; pin = p; wr = w; rd = r; sel = s; wd = d;
        ld = w & s;
        ev = m ? (h3 & ~h2) : t;
        uf = ev & ~ld & (m_cnt == 16'h0000);
        @(posedge clk);
        #1;
        if (uf && m_arm) m_flag = 1'b1;
        else if (ld || (r && !s)) m_flag = 1'b0;
        if (ld) m_arm = 1'b1;
        else if (uf) m_arm = 1'b0;
        if (ld) m_cnt = {d, m_latch};
        else if (ev) m_cnt = m_cnt - 16'd1;
        if (w && !s) m_latch = d;
        h3 = h2; h2 = h1; h1 = p;
        chk({tag, " flag"}, flag, m_flag);
        chk({tag, " rdata"}, rdata, exp_rd(s, m_cnt));
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", total - fails, total);
    endtask

    initial begin
        #(150000 * 5);
        fails++; total++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        logic [15:0] c0;
        logic m_r;
        void'($urandom(32'h5EED_0011));
        repeat (4) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        #2; // between edges
        chk("R1 flag", flag, 1'b0);
        chk("R1 low", rdata, 8'hFF);
        step(0,0,0,0,0,1,8'h00,"R1 high");
        chk("R1 high byte", rdata, 8'hFF);
        step(0,0,0,1,0,1,8'h12,"R1 load");
        chk("R1 latch reset", rdata, 8'h12);
        step(0,0,0,0,0,0,8'h00,"R1 low");
        chk("R1 latch reset low", rdata, 8'hFF);
        // R2 holding byte only
        step(0,0,0,1,0,0,8'h34,"R2 write");
        chk("R2 counter unchanged", rdata, 8'hFF);
        step(0,0,0,1,0,1,8'h00,"R3 load");
        step(0,0,0,0,0,0,8'h00,"R3 low");
        chk("R3 loaded low", rdata, 8'h34);
        // R6 underflow after N+1 ticks
        step(0,0,0,1,0,0,8'h02,"R6 latch");
        step(0,0,0,1,0,1,8'h00,"R6 load");
        step(1,0,0,0,0,0,8'h00,"R6 tick");
        step(1,0,0,0,0,0,8'h00,"R6 tick");
        chk("R6 at zero no flag", flag, 1'b0);
        step(1,0,0,0,0,1,8'h00,"R6 wrap");
        chk("R6 flag set", flag, 1'b1);
        chk("R6 wrap high", rdata, 8'hFF);
        // R8 read side effects
        step(0,0,0,0,1,1,8'h00,"R8 read high");
        chk("R8 high read keeps flag", flag, 1'b1);
        step(0,0,0,0,1,0,8'h00,"R8 read low");
        chk("R8 low read clears flag", flag, 1'b0);
        // R7 second wrap without reload
        for (int i = 0; i < 65536; i++) step(1,0,0,0,0,0,8'h00,"R7 run");
        chk("R7 no second flag", flag, 1'b0);
        chk("R7 wrapped low", rdata, 8'hFF);
        // R4 pin ignored in timed mode
        for (int i = 0; i < 6; i++) step(0,0,i[0],0,0,0,8'h00,"R4 pin");
        chk("R4 stable", rdata, 8'hFF);
        // R5 pulse counting
        step(0,1,1,1,0,0,8'h05,"R5 latch");
        step(0,1,1,1,0,1,8'h00,"R5 load");
        for (int i = 0; i < 4; i++) step(1,1,1,0,0,0,8'h00,"R5 tick ignored");
        chk("R5 ticks ignored", rdata, 8'h05);
        c0 = m_cnt;
        step(1,1,0,0,0,0,8'h00,"R5 fall");
        chk("R5 edge1", rdata, c0[7:0]);
        step(1,1,0,0,0,0,8'h00,"R5 fall");
        chk("R5 edge2", rdata, c0[7:0]);
        step(1,1,0,0,0,0,8'h00,"R5 fall");
        chk("R5 edge3", rdata, c0[7:0] - 8'd1);
        for (int i = 0; i < 5; i++) step(0,1,1,0,0,0,8'h00,"R5 rise");
        chk("R5 rise ignored", rdata, c0[7:0] - 8'd1);
        // R9 priorities
        step(0,0,1,1,0,0,8'h00,"R9 latch");
        step(0,0,1,1,0,1,8'h00,"R9 load");
        step(1,0,1,0,1,0,8'h00,"R9 set vs clear");
        chk("R9 set wins", flag, 1'b1);
        step(1,0,1,1,0,1,8'h07,"R9 load vs tick");
        chk("R9 load wins", rdata, 8'h07);
        // R10 plus random mix
        m_r = 1'b0;
        for (int i = 0; i < 4000; i++) begin
            logic t, p, w, r, s;
            logic [7:0] d;
            if ($urandom % 64 == 0) m_r = ~m_r;
            t = ($urandom % 2) == 1;
            p = ($urandom % 3) != 0;
            w = ($urandom % 16) == 0;
            r = ($urandom % 8) == 0;
            s = ($urandom % 2) == 1;
            d = ($urandom % 8 == 0) ? 8'h00 : 8'($urandom % 4);
            step(t, m_r, p, w, r, s, d, m_r ? "R5 R10 rand" : "R4 R10 rand");
        end
        summary();
        $finish;
    end
endmodule